// File: doc/BRIEF.md
# Serial Flash Page-Program Write Buffer

This block stages one flash page of write data and sends it to a serial NOR flash as a single page-program transfer. Software streams the page through one 32-bit data register, loads a start address into four byte-wide address registers, and writes a trigger code to the command register. The block then drives chip select, serial clock and the data line (single-bit, clock mode 0). It sends the program opcode, three or four address bytes with the most significant byte first, and then every byte of the page in buffer order.

The page storage is shared with a read-prefetch function. A configuration bit asks for the storage to be handed over to page programming. The bit reads back the new value only once the hand-over has completed, so software polls it. A second trigger code runs a single-byte program of the byte held in a data register. After that transfer the address registers step forward by one, so a run of single-byte writes fills consecutive locations.

The register port is a valid/ready request channel. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a flash transfer is running, `req_ready` stays low for write requests, so the requester holds the write and its fields stable until the transfer ends. Read requests are never stalled. Each accepted read returns its data on `rsp_rdata` with `rsp_valid` high for exactly one cycle, starting on the edge that accepts the read.

Top module: `flash_page_writer`

## Requirements
- R1: Each accepted write to offset 0x98 in page-program mode stores 4 buffer bytes at the write pointer: bits [7:0] go to the lowest-addressed byte and bits [31:24] to the highest. Writes after the 32nd (buffer full, 128 bytes) are ignored.
- R2: Bit 0 of offset 0x64 requests the buffer use (0 read-prefetch, 1 page-program). Reading offset 0x64 returns the granted use in bit 0, which takes the requested value MODE_DELAY (4) cycles after the write. While the granted use is read-prefetch, writes to 0x98 are ignored.
- R3: The write pointer returns to byte 0 when page-program use is granted and after every completed page program.
- R4: Writing 0x10 to offset 0x00 in page-program mode starts a transfer with chip select low throughout: opcode 0x02, the address bytes, then all 128 buffer bytes in order. Offset 0x00 reads 0x10 while the transfer runs and 0x00 once chip select has returned high.
- R5: Writing 0x10 to offset 0x00 while the granted use is read-prefetch starts nothing: chip select stays high and offset 0x00 reads 0x00.
- R6: The address is held at offsets 0x10 (bits 7:0), 0x14 (15:8), 0x18 (23:16) and 0xC8 (31:24). When bit 4 of offset 0xCC is 1, four address bytes are sent; when it is 0, only bits 23:0 are sent as three bytes. All of these registers read back their stored value.
- R7: Writing 0x90 to offset 0x00 sends opcode 0x02, the address bytes and the byte held at offset 0x1C. Offset 0x00 reads 0x90 while this runs. When it ends, the 32-bit address rises by one, with carry between the byte registers.
- R8: The serial clock idles low whenever chip select is high. Each clock phase lasts SCK_HALF (2) system cycles. The data line changes only while the serial clock is low, and bits go out most significant bit first.
- R9: While a transfer runs, write requests see `req_ready` low and are held, then accepted after the transfer ends. Read requests are always accepted and answered with `rsp_valid` for one cycle.
- R10: After reset, chip select is high, the serial clock is low, and offsets 0x00, 0x64 and 0xCC read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Read data |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The bench targets the write pointer at its boundaries. A pointer that is not cleared after a program would shift the next page. One that is not cleared when the mode is granted would keep the words written before, and one that does not stop when the buffer is full would wrap and overwrite the first word. It sends a page in read-prefetch mode, where a missing gate would let the buffer be corrupted, and it checks the trigger in that mode, where a design that starts anyway would drive chip select. It drives an address increment that carries across byte registers and compares three-byte against four-byte framing, where errors show up as wrong or extra address bytes on the wire. It also holds a write during a transfer, which exposes a port that accepts requests while busy.

// File: rtl/flash_pw_pkg.sv
package flash_pw_pkg;
  localparam logic [7:0] OFS_CMD    = 8'h00;
  localparam logic [7:0] OFS_ADR0   = 8'h10;
  localparam logic [7:0] OFS_ADR1   = 8'h14;
  localparam logic [7:0] OFS_ADR2   = 8'h18;
  localparam logic [7:0] OFS_BYTE   = 8'h1C;
  localparam logic [7:0] OFS_USE    = 8'h64;
  localparam logic [7:0] OFS_PAGE   = 8'h98;
  localparam logic [7:0] OFS_WIDTH  = 8'hCC;
  localparam logic [7:0] OFS_ADR3   = 8'hC8;

  localparam logic [7:0] TRIG_PAGE  = 8'h10;
  localparam logic [7:0] TRIG_BYTE  = 8'h90;
  localparam logic [7:0] OP_PROGRAM = 8'h02;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SEND  = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fpw_regs.sv
module fpw_regs
  import flash_pw_pkg::*;
#(
  parameter int MODE_DELAY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic        busy,
  input  logic [7:0]  cmd_status,
  input  logic        byte_done,
  output logic        start_page,
  output logic        start_byte,
  output logic [31:0] addr_q,
  output logic        four_byte,
  output logic [7:0]  byte_data,
  output logic        use_page,
  output logic        use_grant,
  output logic        page_wr_en,
  output logic [31:0] page_wr_data
);
  localparam int DCW = (MODE_DELAY > 1) ? $clog2(MODE_DELAY) : 1;

  logic          wr_acc, rd_acc;
  logic          use_req;
  logic [DCW-1:0] dly_cnt;
  logic          grant_now;

  assign req_ready = !(busy && req_write);
  assign wr_acc    = req_valid && req_ready && req_write;
  assign rd_acc    = req_valid && req_ready && !req_write;

  assign start_page = wr_acc && (req_addr == OFS_CMD) && (req_wdata[7:0] == TRIG_PAGE) && use_page;
  assign start_byte = wr_acc && (req_addr == OFS_CMD) && (req_wdata[7:0] == TRIG_BYTE);
  assign page_wr_en   = wr_acc && (req_addr == OFS_PAGE) && use_page;
  assign page_wr_data = req_wdata;

  // Hand-over of the shared storage: the granted use follows the request
  // only after it has differed for MODE_DELAY cycles.
  assign grant_now = (use_req != use_page) && (dly_cnt == DCW'(MODE_DELAY - 1));
  assign use_grant = grant_now && use_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_req  <= 1'b0;
      use_page <= 1'b0;
      dly_cnt  <= '0;
    end else begin
      if (wr_acc && req_addr == OFS_USE) use_req <= req_wdata[0];
      if (use_req == use_page) begin
        dly_cnt <= '0;
      end else if (grant_now) begin
        use_page <= use_req;
        dly_cnt  <= '0;
      end else begin
        dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      four_byte <= 1'b0;
      byte_data <= '0;
    end else begin
      if (byte_done) begin
        addr_q <= addr_q + 32'd1;
      end else if (wr_acc) begin
        case (req_addr)
          OFS_ADR0:  addr_q[7:0]   <= req_wdata[7:0];
          OFS_ADR1:  addr_q[15:8]  <= req_wdata[7:0];
          OFS_ADR2:  addr_q[23:16] <= req_wdata[7:0];
          OFS_ADR3:  addr_q[31:24] <= req_wdata[7:0];
          OFS_BYTE:  byte_data     <= req_wdata[7:0];
          OFS_WIDTH: four_byte     <= req_wdata[4];
          default: ;
        endcase
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (req_addr)
      OFS_CMD:   rd_mux = {24'd0, cmd_status};
      OFS_ADR0:  rd_mux = {24'd0, addr_q[7:0]};
      OFS_ADR1:  rd_mux = {24'd0, addr_q[15:8]};
      OFS_ADR2:  rd_mux = {24'd0, addr_q[23:16]};
      OFS_ADR3:  rd_mux = {24'd0, addr_q[31:24]};
      OFS_BYTE:  rd_mux = {24'd0, byte_data};
      OFS_USE:   rd_mux = {31'd0, use_page};
      OFS_WIDTH: rd_mux = {27'd0, four_byte, 4'd0};
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_mux;
    end
  end

  p_grant_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_page != $past(use_page)) |-> (use_page == $past(use_req)));

  p_addr_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_done) |=> $stable(addr_q));

  p_rsp_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(rd_acc)) |-> 1'b0);
endmodule

// File: rtl/fpw_page_buf.sv
module fpw_page_buf #(
  parameter int PAGE_BYTES = 128,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          wr_en,
  input  logic [8*WORD_BYTES-1:0]       wr_data,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [7:0]                    rd_byte
);
  localparam int WORDS = PAGE_BYTES / WORD_BYTES;
  localparam int PW    = $clog2(WORDS + 1);
  localparam int WIW   = $clog2(WORDS);
  localparam int BSW   = $clog2(WORD_BYTES);

  logic [8*WORD_BYTES-1:0] mem [WORDS];
  logic [PW-1:0]           wptr;
  logic                    full;

  assign full = (wptr == PW'(WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wptr <= '0;
    else if (clear)            wptr <= '0;
    else if (wr_en && !full)   wptr <= wptr + 1'b1;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[w] <= '0;
      else if (!clear && wr_en && !full && wptr == PW'(w)) mem[w] <= wr_data;
    end
  end

  logic [8*WORD_BYTES-1:0] rd_word;
  assign rd_word = mem[rd_idx[$clog2(PAGE_BYTES)-1:BSW]];
  assign rd_byte = rd_word[8*rd_idx[BSW-1:0] +: 8];

  p_ptr_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= PW'(WORDS));

  p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> full);

  p_clear_rewinds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (wptr == '0));

  localparam int UNUSED_WIW = WIW;
endmodule

// File: rtl/fpw_spi_tx.sv
module fpw_spi_tx #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  output logic       byte_ready,
  input  logic [7:0] byte_in,
  output logic       sck,
  output logic       mosi
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic          active;
  logic [7:0]    shreg;
  logic [2:0]    bitn;
  logic [DW-1:0] div;
  logic          phase_end;

  assign byte_ready = !active;
  assign mosi       = shreg[7];
  assign phase_end  = (div == DW'(SCK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      shreg  <= '0;
      bitn   <= '0;
      div    <= '0;
      sck    <= 1'b0;
    end else if (!active) begin
      if (byte_valid) begin
        active <= 1'b1;
        shreg  <= byte_in;
        bitn   <= '0;
        div    <= '0;
        sck    <= 1'b0;
      end
    end else if (!phase_end) begin
      div <= div + 1'b1;
    end else begin
      div <= '0;
      if (!sck) begin
        sck <= 1'b1;
      end else begin
        sck <= 1'b0;
        if (bitn == 3'd7) begin
          active <= 1'b0;
        end else begin
          bitn  <= bitn + 1'b1;
          shreg <= {shreg[6:0], 1'b0};
        end
      end
    end
  end

  p_sck_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);

  p_mosi_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import flash_pw_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int SCK_HALF   = 2,
  parameter int MODE_DELAY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi
);
  localparam int BIW = $clog2(PAGE_BYTES);
  localparam int IW  = $clog2(PAGE_BYTES + 6);

  seq_state_e     state;
  logic           kind_page;
  logic [IW-1:0]  idx, last_idx, addr_n, data_idx;
  logic           busy, start_page, start_byte, byte_done, page_done;
  logic [31:0]    addr_q;
  logic           four_byte, use_page, use_grant, page_wr_en;
  logic [31:0]    page_wr_data;
  logic [7:0]     byte_data, buf_byte, tx_byte, cmd_status;
  logic           tx_valid, tx_ready;

  assign busy       = (state != SQ_IDLE);
  assign spi_cs_n   = !busy;
  assign cmd_status = busy ? (kind_page ? TRIG_PAGE : TRIG_BYTE) : 8'h00;

  fpw_regs #(.MODE_DELAY(MODE_DELAY)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .cmd_status(cmd_status), .byte_done(byte_done),
    .start_page(start_page), .start_byte(start_byte),
    .addr_q(addr_q), .four_byte(four_byte), .byte_data(byte_data),
    .use_page(use_page), .use_grant(use_grant),
    .page_wr_en(page_wr_en), .page_wr_data(page_wr_data)
  );

  assign addr_n   = four_byte ? IW'(4) : IW'(3);
  assign last_idx = addr_n + (kind_page ? IW'(PAGE_BYTES) : IW'(1));
  assign data_idx = idx - addr_n - IW'(1);

  fpw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(4)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .clear(use_grant || page_done),
    .wr_en(page_wr_en), .wr_data(page_wr_data),
    .rd_idx(data_idx[BIW-1:0]), .rd_byte(buf_byte)
  );

  // Byte selection: opcode, address bytes high to low, then payload.
  logic [IW-1:0] addr_sel;
  assign addr_sel = addr_n - idx;
  always_comb begin
    if (idx == '0)           tx_byte = OP_PROGRAM;
    else if (idx <= addr_n)  tx_byte = addr_q[8*addr_sel[1:0] +: 8];
    else if (kind_page)      tx_byte = buf_byte;
    else                     tx_byte = byte_data;
  end

  assign tx_valid = (state == SQ_SEND);

  fpw_spi_tx #(.SCK_HALF(SCK_HALF)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(tx_valid), .byte_ready(tx_ready), .byte_in(tx_byte),
    .sck(spi_sck), .mosi(spi_mosi)
  );

  logic finish;
  assign finish    = (state == SQ_DRAIN) && tx_ready;
  assign page_done = finish && kind_page;
  assign byte_done = finish && !kind_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      kind_page <= 1'b0;
      idx       <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_page || start_byte) begin
            state     <= SQ_SEND;
            kind_page <= start_page;
            idx       <= '0;
          end
        end
        SQ_SEND: begin
          if (tx_ready) begin
            if (idx == last_idx) state <= SQ_DRAIN;
            else                 idx   <= idx + 1'b1;
          end
        end
        SQ_DRAIN: begin
          if (tx_ready) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  p_sck_low_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  p_deselect_after_last_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(tx_ready));

  p_no_write_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && req_valid && req_write) |-> !req_ready);

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= last_idx));
endmodule

// File: tb/flash_page_writer_test.sv
module flash_page_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, spi_cs_n, spi_sck, spi_mosi;
  logic [31:0] rsp_rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_page_writer uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Wire monitor: rebuilds bytes from MOSI on rising SCK.
  logic [7:0] wire_bytes[$];
  int         frame_len[$];
  logic [7:0] shacc;
  int         bits = 0, cur_len = 0;
  always @(posedge spi_sck) if (!spi_cs_n) begin
    shacc = {shacc[6:0], spi_mosi};
    bits++;
    if (bits == 8) begin wire_bytes.push_back(shacc); bits = 0; cur_len++; end
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    frame_len.push_back(cur_len);
    cur_len = 0; bits = 0;
  end

  // Per-clock model: expected port behaviour derived from the requirements.
  int  hi_run = 0;
  logic prev_sck = 0, prev_mosi = 0;
  always @(negedge clk) if (rst_n && !done) begin
    check("R8 sck low when deselected", spi_cs_n && spi_sck, 0);
    if (spi_sck && prev_sck) check("R8 mosi stable while sck high", spi_mosi, prev_mosi);
    if (spi_sck) hi_run++;
    else begin
      if (prev_sck) check("R8 sck high phase length", hi_run, 2);
      hi_run = 0;
    end
    if (req_valid && req_write && !spi_cs_n) check("R9 write stalled while busy", req_ready, 0);
    if (req_valid && !req_write) check("R9 read always accepted", req_ready, 1);
    prev_sck = spi_sck; prev_mosi = spi_mosi;
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    check("R9 read response valid", rsp_valid, 1);
    d = rsp_rdata;
    req_valid = 0;
    @(negedge clk);
    check("R9 response lasts one cycle", rsp_valid, 0);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int guard = 0;
    do begin bus_rd(8'h00, v); guard++; end while (v[7:0] != 0 && guard < 3000);
    check("R4 command clears at end", v, 0);
  endtask

  task automatic set_use(input bit u);
    logic [31:0] v;
    int polls = 0;
    bus_wr(8'h64, {31'd0, u});
    bus_rd(8'h64, v);
    check("R2 grant not yet visible", v[0], !u);
    do begin bus_rd(8'h64, v); polls++; end while (v[0] != u && polls < 20);
    check("R2 grant reaches request", v[0], u);
  endtask

  task automatic set_addr(input logic [31:0] a, input bit four);
    bus_wr(8'h10, {24'd0, a[7:0]});
    bus_wr(8'h14, {24'd0, a[15:8]});
    bus_wr(8'h18, {24'd0, a[23:16]});
    bus_wr(8'hC8, {24'd0, a[31:24]});
    bus_wr(8'hCC, {27'd0, four, 4'd0});
  endtask

  task automatic check_frame(input string req, input logic [7:0] exp[$]);
    int len;
    n_tests++;
    if (frame_len.size() == 0) begin
      n_fail++; $display("FAIL %s actual=no frame expected=%0d bytes", req, exp.size());
      return;
    end
    len = frame_len.pop_front();
    if (len != exp.size()) begin
      n_fail++; $display("FAIL %s length actual=%0d expected=%0d", req, len, exp.size());
    end
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = wire_bytes.pop_front();
      if (i < exp.size() && b !== exp[i]) begin
        n_fail++;
        $display("FAIL %s byte %0d actual=%0h expected=%0h", req, i, b, exp[i]);
        break;
      end
    end
  endtask

  function automatic logic [31:0] pat(input int seed, input int w);
    return 32'h9E3779B9 * (seed * 64 + w + 1) ^ (32'h01010101 * w);
  endfunction

  task automatic build_page(input int seed, input logic [31:0] a, input bit four,
                            inout logic [7:0] q[$]);
    q.delete();
    q.push_back(8'h02);
    if (four) q.push_back(a[31:24]);
    q.push_back(a[23:16]); q.push_back(a[15:8]); q.push_back(a[7:0]);
    for (int w = 0; w < 32; w++) begin
      logic [31:0] d;
      d = pat(seed, w);
      for (int b = 0; b < 4; b++) q.push_back(d[8*b +: 8]);
    end
  endtask

  task automatic fill(input int seed, input int words);
    for (int w = 0; w < words; w++) bus_wr(8'h98, pat(seed, w));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  q[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 cs high", spi_cs_n, 1);
    check("R10 sck low", spi_sck, 0);
    check("R10 ready", req_ready, 1);
    bus_rd(8'h00, v); check("R10 command reads 0", v, 0);
    bus_rd(8'h64, v); check("R10 use reads 0", v, 0);
    bus_rd(8'hCC, v); check("R10 width reads 0", v, 0);

    // R5 trigger ignored in read-prefetch use
    bus_wr(8'h00, 32'h10);
    bus_rd(8'h00, v); check("R5 command stays 0", v, 0);
    repeat (20) @(negedge clk);
    check("R5 no frame", frame_len.size(), 0);
    check("R5 cs stays high", spi_cs_n, 1);

    // R1 R2 R4 R6 three-byte page, plus a stalled write (R9)
    set_use(1);
    set_addr(32'h12345678, 0);
    bus_rd(8'h14, v); check("R6 address byte readback", v, 32'h56);
    fill(1, 32);
    bus_wr(8'h00, 32'h10);
    bus_rd(8'h00, v); check("R4 command reads 0x10 while busy", v, 32'h10);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h1C; req_wdata = 32'h77; #1;
    check("R9 held write sees ready low", req_ready, 0);
    while (!req_ready) begin @(negedge clk); #1; end
    check("R9 held write accepted after end", spi_cs_n, 1);
    @(negedge clk); req_valid = 0; req_write = 0;
    wait_idle();
    build_page(1, 32'h12345678, 0, q);
    check_frame("R4 R6 R1 three-byte page", q);
    bus_rd(8'h1C, v); check("R9 held write landed", v, 32'h77);

    // R3 pointer rewinds after program; R1 overflow ignored; R6 four-byte
    fill(2, 32);
    for (int k = 0; k < 4; k++) bus_wr(8'h98, 32'hDEAD0000 + k);
    set_addr(32'h12345678, 1);
    bus_wr(8'h00, 32'h10);
    wait_idle();
    build_page(2, 32'h12345678, 1, q);
    check_frame("R3 R1 R6 four-byte page after rewind", q);

    // R3 rewind on grant
    fill(3, 5);
    set_use(0);
    set_use(1);
    fill(3, 32);
    bus_wr(8'h00, 32'h10);
    wait_idle();
    build_page(3, 32'h12345678, 1, q);
    check_frame("R3 rewind on grant", q);

    // R2 page writes ignored in read-prefetch use
    set_use(0);
    fill(9, 32);
    set_use(1);
    bus_wr(8'h00, 32'h10);
    wait_idle();
    build_page(3, 32'h12345678, 1, q);
    check_frame("R2 writes ignored in read use", q);

    // R7 single-byte writes with carry
    set_use(0);
    set_addr(32'h0100FFFF, 1);
    bus_wr(8'h1C, 32'hA5);
    bus_wr(8'h00, 32'h90);
    bus_rd(8'h00, v); check("R7 command reads 0x90 while busy", v, 32'h90);
    wait_idle();
    q = '{8'h02, 8'h01, 8'h00, 8'hFF, 8'hFF, 8'hA5};
    check_frame("R7 byte frame", q);
    bus_rd(8'h10, v); check("R7 addr byte0 after carry", v, 32'h00);
    bus_rd(8'h14, v); check("R7 addr byte1 after carry", v, 32'h00);
    bus_rd(8'h18, v); check("R7 addr byte2 after carry", v, 32'h01);
    bus_rd(8'hC8, v); check("R7 addr byte3 unchanged", v, 32'h01);
    bus_wr(8'hCC, 32'h0);
    bus_wr(8'h1C, 32'h5A);
    bus_wr(8'h00, 32'h90);
    wait_idle();
    q = '{8'h02, 8'h01, 8'h00, 8'h00, 8'h5A};
    check_frame("R7 R6 second byte three-byte", q);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule